// File: doc/BRIEF.md
# Nested Interrupt Priority Arbiter

This block decides which of a set of interrupt request lines is granted next, given what the processor is already servicing. Every source carries a 2-bit level (0 is the most urgent, 3 the least), a mask bit, and a flag that marks it as a hardware-serviced (macro) request. The arbiter keeps a four-bit in-service record, one bit per level. It combines that record with a global enable flag, a flag that allows nesting inside level 3, and two in-service inputs for non-maskable interrupts. From these it decides which requests may interrupt. Among the requests that qualify, the one with the lowest level wins. Ties go to the lowest source index.

A grant is a one-cycle registered pulse on `ack` that carries the source index, its level and whether it was a macro request. A maskable grant sets the in-service bit for its level and clears the enable flag. Software sets the flag again with `ie_set` before any further maskable nesting can happen. A macro grant leaves both untouched. A `reti` strobe closes the most urgent open level by clearing the lowest-numbered set bit of the record. The non-maskable in-service bits are inputs from outside the block, so `reti` never clears them.

The controller is a two-state machine. In `ST_IDLE` it arbitrates every cycle. The transition `IDLE_TO_ACK` is taken when any request qualifies, and it loads the grant registers. In `ST_ACK` the acknowledge is driven and new requests are ignored. The transition `ACK_TO_IDLE` is always taken on the following edge.

Top module: `irq_nest_arbiter`

## Requirements
- R1: While reset is held, `ack` is 0, `ie` is 0 and `isr` is 4'b0000.
- R2: With `isr` at 0, `ie` at 1 and both `nmi_srv` bits at 0, any unmasked request at any level is granted.
- R3: Among the requests that qualify in a cycle, the lowest level wins, and within that level the lowest source index wins. `ack` rises on the edge after the request is sampled, with `ack_id`, `ack_lvl` and `ack_macro` valid while it is high.
- R4: `ack` is high for exactly one cycle per grant. A request present while `ack` is high is not granted in that cycle, so two consecutive cycles never both show `ack` high.
- R5: A maskable grant clears `ie` on the same edge that raises `ack`. `ie_set` sets `ie` to 1 on the next edge unless a maskable grant occurs on that edge, in which case `ie` becomes 0.
- R6: While `ie` is 0, only requests with their macro flag set are granted.
- R7: When the lowest set bit of `isr` is bit 3, maskable requests at levels 0 to 2 qualify. Level 3 requests qualify only when `nest_same` is 1.
- R8: When the lowest set bit of `isr` is bit 2, only levels 0 and 1 qualify. When it is bit 1, only level 0 qualifies. When it is bit 0, no maskable request qualifies.
- R9: While either bit of `nmi_srv` is 1, only macro requests are granted.
- R10: A maskable grant at level L sets `isr[L]` (bit 0 for level 0 up to bit 3 for level 3). A macro grant leaves `isr` and `ie` unchanged.
- R11: A `reti` pulse clears the lowest-numbered set bit of `isr` on the next edge. When a maskable grant happens on the same edge, the clear is applied first and the new bit is then set.
- R12: A request whose mask bit is 1 is never granted, whether or not it is a macro request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_SRC | Request level per source |
| mask | input | N_SRC | 1 blocks the source |
| is_macro | input | N_SRC | 1 marks a hardware-serviced request |
| prio | input | 2*N_SRC | Level of source i in bits [2i+1:2i], 0 most urgent |
| ie_set | input | 1 | Pulse that sets the enable flag |
| nest_same | input | 1 | Allows level 3 inside level 3 |
| nmi_srv | input | 2 | Non-maskable interrupts in service |
| reti | input | 1 | Return-from-interrupt pulse |
| ack | output | 1 | One-cycle grant pulse |
| ack_id | output | $clog2(N_SRC) | Granted source index |
| ack_lvl | output | 2 | Level of the granted source |
| ack_macro | output | 1 | Grant was a macro request |
| ie | output | 1 | Global interrupt-enable flag |
| isr | output | 4 | In-service record, bit L for level L |

## Verification
The hardest state to reach is a stack of several open levels, for example 4'b1100 or 4'b0110. From the ports it can only be built by a chain of grants. Each grant must be preceded by an `ie_set` pulse, because every maskable grant turns the flag off again. The stimulus therefore runs fixed sequences of enable pulse, request and release to stack levels, and then presents requests just above and just below the current level. A behavioural model in the bench is stepped alongside and compared with every output on every clock. That comparison also covers the cycles in which `reti` and a grant coincide, and the cycles in which a held macro request meets the acknowledge lockout.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int LVL_W   = 2;
    localparam int NUM_LVL = 1 << LVL_W;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } arb_state_t;
endpackage

// File: rtl/irq_level_gate.sv
module irq_level_gate
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic [N_SRC-1:0]       req,
    input  logic [N_SRC-1:0]       mask,
    input  logic [N_SRC-1:0]       is_macro,
    input  logic [LVL_W*N_SRC-1:0] prio,
    input  logic                   ie,
    input  logic                   nest_same,
    input  logic                   busy,
    input  logic [1:0]             nmi_srv,
    input  logic [NUM_LVL-1:0]     isr,
    output logic [N_SRC-1:0]       elig
);
    logic [NUM_LVL-1:0] lvl_ok;
    logic               mask_open;

    // Levels that may preempt the most urgent open level.
    always_comb begin
        if (isr[0])      lvl_ok = 4'b0000;
        else if (isr[1]) lvl_ok = 4'b0001;
        else if (isr[2]) lvl_ok = 4'b0011;
        else if (isr[3]) lvl_ok = {nest_same, 3'b111};
        else             lvl_ok = 4'b1111;
    end

    assign mask_open = ie && (nmi_srv == 2'b00);

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign elig[i] = !busy && req[i] && !mask[i] &&
                         (is_macro[i] || (mask_open && lvl_ok[prio[LVL_W*i +: LVL_W]]));
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 8,
    localparam int ID_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]       elig,
    input  logic [LVL_W*N_SRC-1:0] prio,
    output logic                   found,
    output logic [ID_W-1:0]        win_id,
    output logic [LVL_W-1:0]       win_lvl
);
    // Scan from least to most urgent; the last match overrides earlier ones.
    always_comb begin
        found   = 1'b0;
        win_id  = '0;
        win_lvl = '0;
        for (int l = NUM_LVL - 1; l >= 0; l--) begin
            for (int i = N_SRC - 1; i >= 0; i--) begin
                if (elig[i] && (prio[LVL_W*i +: LVL_W] == LVL_W'(l))) begin
                    found   = 1'b1;
                    win_id  = ID_W'(i);
                    win_lvl = LVL_W'(l);
                end
            end
        end
    end
endmodule

// File: rtl/irq_nest_arbiter.sv
module irq_nest_arbiter
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 8,
    localparam int ID_W = $clog2(N_SRC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_SRC-1:0]       req,
    input  logic [N_SRC-1:0]       mask,
    input  logic [N_SRC-1:0]       is_macro,
    input  logic [2*N_SRC-1:0]     prio,
    input  logic                   ie_set,
    input  logic                   nest_same,
    input  logic [1:0]             nmi_srv,
    input  logic                   reti,
    output logic                   ack,
    output logic [ID_W-1:0]        ack_id,
    output logic [1:0]             ack_lvl,
    output logic                   ack_macro,
    output logic                   ie,
    output logic [3:0]             isr
);
    arb_state_t          state, state_n;
    logic [N_SRC-1:0]    elig;
    logic                found;
    logic [ID_W-1:0]     win_id;
    logic [LVL_W-1:0]    win_lvl;
    logic                grant, grant_mask;
    logic [NUM_LVL-1:0]  isr_low, isr_n;

    irq_level_gate #(.N_SRC(N_SRC)) u_gate (
        .req(req), .mask(mask), .is_macro(is_macro), .prio(prio),
        .ie(ie), .nest_same(nest_same), .busy(state == ST_ACK),
        .nmi_srv(nmi_srv), .isr(isr), .elig(elig)
    );

    irq_pick #(.N_SRC(N_SRC)) u_pick (
        .elig(elig), .prio(prio), .found(found),
        .win_id(win_id), .win_lvl(win_lvl)
    );

    assign grant      = (state == ST_IDLE) && found;
    assign grant_mask = grant && !is_macro[win_id];

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        unique case (state)
            ST_IDLE: state_n = found ? ST_ACK : ST_IDLE;   // IDLE_TO_ACK
            ST_ACK:  state_n = ST_IDLE;                     // ACK_TO_IDLE
            default: state_n = ST_IDLE;
        endcase
    end

    // Outputs and in-service state.
    assign ack     = (state == ST_ACK);
    assign isr_low = isr & (~isr + 4'd1);
    assign isr_n   = (reti ? (isr & ~isr_low) : isr) |
                     (grant_mask ? (4'b0001 << win_lvl) : 4'b0000);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_id    <= '0;
            ack_lvl   <= '0;
            ack_macro <= 1'b0;
            ie        <= 1'b0;
            isr       <= '0;
        end else begin
            if (grant) begin
                ack_id    <= win_id;
                ack_lvl   <= win_lvl;
                ack_macro <= is_macro[win_id];
            end
            if (grant_mask)  ie <= 1'b0;
            else if (ie_set) ie <= 1'b1;
            isr <= isr_n;
        end
    end

    // Assertions
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    a_r5_ie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !ack_macro) |-> !ie);
    a_r6_ie_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !$past(ie)) |-> ack_macro);
    a_r8_level0_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && $past(isr[0])) |-> ack_macro);
    a_r7_same_level: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !ack_macro && ack_lvl == 2'd3 && $past(isr) == 4'b1000) |-> $past(nest_same));
    a_r9_nmi_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && $past(nmi_srv) != 2'b00) |-> ack_macro);
    a_r10_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !ack_macro) |-> isr[ack_lvl]);
    a_r10_macro_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ack_macro && !$past(reti)) |-> (isr == $past(isr)));
    a_r12_masked: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (($past(mask) >> ack_id) & N_SRC'(1)) == '0);
endmodule

// File: tb/irq_nest_arbiter_tb.sv
module irq_nest_arbiter_tb;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [N-1:0]   req = '0, mask = '0, is_macro = '0;
    logic [2*N-1:0] prio = '0;
    logic           ie_set = 0, nest_same = 0, reti = 0;
    logic [1:0]     nmi_srv = 2'b00;
    logic           ack, ack_macro, ie;
    logic [2:0]     ack_id;
    logic [1:0]     ack_lvl;
    logic [3:0]     isr;

    irq_nest_arbiter #(.N_SRC(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .mask(mask), .is_macro(is_macro),
        .prio(prio), .ie_set(ie_set), .nest_same(nest_same), .nmi_srv(nmi_srv),
        .reti(reti), .ack(ack), .ack_id(ack_id), .ack_lvl(ack_lvl),
        .ack_macro(ack_macro), .ie(ie), .isr(isr)
    );

    int checks = 0, fails = 0;

    // Reference model state
    bit       m_ack, m_mac, m_ie;
    int       m_id, m_lvl;
    bit [3:0] m_isr;

    task automatic expect_eq(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit allowed(int l);
        int k = 4;
        for (int j = 3; j >= 0; j--) if (m_isr[j]) k = j;
        if (k == 4) return 1;
        if (k == 3) return (l < 3) || nest_same;
        return l < k;
    endfunction

    task automatic model_step();
        int best = -1;
        int bl = 4;
        bit done = 0;
        bit [3:0] nisr = m_isr;
        if (!m_ack) begin
            for (int i = 0; i < N; i++) begin
                if (req[i] && !mask[i]) begin
                    int l = int'(prio[2*i +: 2]);
                    bit ok = is_macro[i] ? 1'b1 : (m_ie && nmi_srv == 2'b00 && allowed(l));
                    if (ok && l < bl) begin best = i; bl = l; end
                end
            end
        end
        if (reti) for (int k = 0; k < 4; k++) if (!done && nisr[k]) begin nisr[k] = 0; done = 1; end
        if (best >= 0) begin
            m_ack = 1; m_id = best; m_lvl = bl; m_mac = is_macro[best];
            if (!m_mac) begin nisr[bl] = 1; m_ie = 0; end
            else if (ie_set) m_ie = 1;
        end else begin
            m_ack = 0;
            if (ie_set) m_ie = 1;
        end
        m_isr = nisr;
    endtask

    task automatic cycle();
        model_step();
        @(negedge clk);
        expect_eq("R4 ack", ack, m_ack);
        if (m_ack) begin
            expect_eq("R3 ack_id", ack_id, m_id);
            expect_eq("R3 ack_lvl", ack_lvl, m_lvl);
            expect_eq("R10 ack_macro", ack_macro, m_mac);
        end
        expect_eq("R5 ie", ie, m_ie);
        expect_eq("R10 isr", isr, m_isr);
    endtask

    task automatic enable();
        ie_set = 1; cycle(); ie_set = 0;
    endtask

    task automatic ret();
        reti = 1; cycle(); reti = 0;
    endtask

    task automatic set_src(int i, int l, bit mac);
        prio[2*i +: 2] = 2'(l);
        is_macro[i] = mac;
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_eq("R1 ack in reset", ack, 0);
        expect_eq("R1 ie in reset", ie, 0);
        expect_eq("R1 isr in reset", isr, 0);
        rst_n = 1;
        cycle();

        // R2: empty record, enabled, level 2 request accepted
        enable();
        set_src(5, 2, 0); req[5] = 1; cycle(); req[5] = 0;
        expect_eq("R2 grant", ack, 1);
        expect_eq("R2 id", ack_id, 5);
        expect_eq("R10 isr level2", isr, 4'b0100);
        expect_eq("R5 ie cleared", ie, 0);
        cycle();

        // R6: ie=0 blocks maskable, passes macro
        set_src(1, 0, 0); req[1] = 1; cycle(); req[1] = 0;
        expect_eq("R6 maskable blocked", ack, 0);
        set_src(3, 3, 1); req[3] = 1; cycle(); req[3] = 0;
        expect_eq("R6 macro granted", ack, 1);
        expect_eq("R10 macro isr unchanged", isr, 4'b0100);
        cycle();

        // R8: level 2 open
        enable();
        set_src(2, 2, 0); set_src(6, 3, 0); req[2] = 1; req[6] = 1;
        cycle(); expect_eq("R8 level2/3 blocked", ack, 0);
        cycle(); expect_eq("R8 still blocked", ack, 0);
        req[2] = 0; req[6] = 0;
        set_src(4, 1, 0); req[4] = 1; cycle(); req[4] = 0;
        expect_eq("R8 level1 nests", ack_id, 4);
        expect_eq("R10 isr stacked", isr, 4'b0110);
        cycle();

        // R11: returns
        ret(); expect_eq("R11 first return", isr, 4'b0100);
        ret(); expect_eq("R11 second return", isr, 4'b0000);

        // R3: priority order
        enable();
        set_src(7, 0, 0); set_src(2, 1, 0); set_src(0, 1, 0);
        req[7] = 1; req[2] = 1; req[0] = 1; cycle(); req = '0;
        expect_eq("R3 lowest level wins", ack_id, 7);
        ret();
        enable();
        set_src(3, 2, 0); set_src(6, 2, 0); req[3] = 1; req[6] = 1; cycle(); req = '0;
        expect_eq("R3 lowest index wins", ack_id, 3);
        ret();

        // R7: level 3 nesting
        enable();
        set_src(1, 3, 0); req[1] = 1; cycle(); req[1] = 0;
        expect_eq("R7 level3 open", isr, 4'b1000);
        enable();
        set_src(2, 3, 0); nest_same = 0; req[2] = 1; cycle();
        expect_eq("R7 same level blocked", ack, 0);
        nest_same = 1; cycle(); req[2] = 0;
        expect_eq("R7 same level allowed", ack, 1);
        expect_eq("R7 id", ack_id, 2);
        nest_same = 0; cycle();
        enable();
        set_src(0, 2, 0); req[0] = 1; cycle(); req[0] = 0;
        expect_eq("R7 level2 inside 3", isr, 4'b1100);
        ret(); ret();
        expect_eq("R11 cleared", isr, 4'b0000);

        // R8: level 0 open
        enable();
        set_src(5, 0, 0); req[5] = 1; cycle(); req[5] = 0;
        enable();
        set_src(4, 0, 0); req[4] = 1; cycle(); req[4] = 0;
        expect_eq("R8 level0 closed", ack, 0);
        ret();

        // R9: non-maskable in service
        nmi_srv = 2'b01;
        enable();
        set_src(1, 0, 0); req[1] = 1; cycle(); req[1] = 0;
        expect_eq("R9 maskable blocked", ack, 0);
        set_src(3, 1, 1); req[3] = 1; cycle(); req[3] = 0;
        expect_eq("R9 macro granted", ack, 1);
        cycle();
        nmi_srv = 2'b00;

        // R12: masked source
        mask[2] = 1; set_src(2, 0, 1); req[2] = 1; cycle();
        expect_eq("R12 masked macro ignored", ack, 0);
        set_src(2, 0, 0); cycle();
        expect_eq("R12 masked ignored", ack, 0);
        req[2] = 0; mask = '0;

        // R4: held macro request alternates
        set_src(6, 1, 1); req[6] = 1;
        cycle(); expect_eq("R4 first pulse", ack, 1);
        cycle(); expect_eq("R4 lockout", ack, 0);
        cycle(); expect_eq("R4 second pulse", ack, 1);
        req[6] = 0; cycle();

        // R5: grant beats ie_set on the same edge
        set_src(0, 1, 0); req[0] = 1; ie_set = 1; cycle(); ie_set = 0; req[0] = 0;
        expect_eq("R5 grant wins", ie, 0);
        expect_eq("R5 grant", ack, 1);
        ret();

        // R11: return and grant on the same edge
        enable();
        set_src(1, 2, 0); req[1] = 1; cycle(); req[1] = 0;
        enable();
        set_src(4, 1, 0); req[4] = 1; reti = 1; cycle(); req[4] = 0; reti = 0;
        expect_eq("R11 clear then set", isr, 4'b0010);
        ret(); cycle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule